// File: doc/BRIEF.md
# Software Write Protection Sequencer

This block watches every write that a host makes to a byte-wide nonvolatile memory and decides which writes may reach the array. It keeps a protection flag. While the flag is clear, ordinary writes pass. While it is set, ordinary writes are dropped unless a short unlock preamble has just opened a one-shot load window. A longer command string turns the protection off again. Bytes that belong to either command string are held back from the array.

Each write shows up as a single-cycle strobe with its address and data. The page controller sends a one-cycle pulse when a byte or page load has finished, and that pulse closes the window. The flag is an ordinary register that clears on reset. The write qualifier and the suppress signal are combinational, so they can gate the programming request in the same cycle as the strobe.

Top module: `wprot_seq`

## Requirements
- R1: After reset the flag is clear and a plain write gives wr_allow=1. In a cycle without wr_evt, both wr_allow and cmd_suppress are 0.
- R2: The lock string sets the flag and opens the load window in the cycle after its last byte, even when the flag was already set. The string is data 8'hAA at address 16'h5555, then 8'h55 at 16'h2AAA, then 8'hA0 at 16'h5555.
- R3: While the window is open, ordinary writes give wr_allow=1. A page_done pulse closes the window from the next cycle on, and the flag stays set.
- R4: The six-byte release string clears the flag and the window in the cycle after its last byte. The string is 8'hAA at 5555, 8'h55 at 2AAA, 8'h80 at 5555, 8'hAA at 5555, 8'h55 at 2AAA, 8'h20 at 5555.
- R5: Address bit 15 plays no part in matching a command byte.
- R6: A write that matches the next expected command byte gives cmd_suppress=1 and wr_allow=0.
- R7: A write that does not fit the partial string resets the matcher and is judged as an ordinary write. If that write is itself 8'hAA at 5555, it counts as the first byte of a new string.
- R8: While the flag is set and the window is closed, an ordinary write gives wr_allow=0 and cmd_suppress=0.
- R9: The third byte picks the branch: 8'hA0 ends the lock string, and 8'h80 continues toward the release string.
- R10: A write in the same cycle as page_done is judged with the window still open. If page_done comes in the same cycle as the last lock byte, the window opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| wr_evt | input | 1 | one-cycle write strobe |
| wr_addr | input | 16 | write address |
| wr_data | input | 8 | write data |
| page_done | input | 1 | pulse from the page controller when a load has completed |
| prot_on | output | 1 | protection flag |
| wr_allow | output | 1 | this write may program the array |
| cmd_suppress | output | 1 | this write is a command byte and is held back |

## Verification
Two events can land in the same cycle: a write strobe and the page_done pulse that closes the window. The bench drives them together in two ways. In one, an ordinary write arrives inside an open window and must still be allowed, with writes blocked from the next cycle on. In the other, page_done arrives with the final lock byte, and the window must be open afterwards. The same pairings also come up in the random phase, where page_done is raised freely alongside the command-biased writes. In both phases a reference model in the bench judges every cycle.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
  typedef enum logic [2:0] {
    MS_IDLE = 3'd0,
    MS_A1   = 3'd1,
    MS_A2   = 3'd2,
    MS_D3   = 3'd3,
    MS_D4   = 3'd4,
    MS_D5   = 3'd5
  } mstate_t;

  localparam logic [15:0] MATCH_MASK = 16'h7FFF;
  localparam logic [15:0] KEY_ADDR_H = 16'h5555;
  localparam logic [15:0] KEY_ADDR_L = 16'h2AAA;
  localparam logic [7:0]  OP_OPEN1   = 8'hAA;
  localparam logic [7:0]  OP_OPEN2   = 8'h55;
  localparam logic [7:0]  OP_LOCK    = 8'hA0;
  localparam logic [7:0]  OP_BRANCH  = 8'h80;
  localparam logic [7:0]  OP_CLEAR   = 8'h20;

  function automatic logic addr_is(input logic [15:0] a, input logic [15:0] key);
    return (a & MATCH_MASK) == (key & MATCH_MASK);
  endfunction

  function automatic logic step_fits(input mstate_t s, input logic [15:0] a,
                                     input logic [7:0] d);
    case (s)
      MS_IDLE, MS_D3: return addr_is(a, KEY_ADDR_H) && d == OP_OPEN1;
      MS_A1,   MS_D4: return addr_is(a, KEY_ADDR_L) && d == OP_OPEN2;
      MS_A2:          return addr_is(a, KEY_ADDR_H) && d == OP_BRANCH;
      MS_D5:          return addr_is(a, KEY_ADDR_H) && d == OP_CLEAR;
      default:        return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/wprot_cmd_match.sv
module wprot_cmd_match
  import wprot_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_evt,
  input  logic [15:0] wr_addr,
  input  logic [7:0]  wr_data,
  output logic        cmd_hit,
  output logic        en_done,
  output logic        dis_done
);
  mstate_t st_q, st_d;

  always_comb begin
    st_d     = st_q;
    cmd_hit  = 1'b0;
    en_done  = 1'b0;
    dis_done = 1'b0;
    if (wr_evt) begin
      if (st_q == MS_A2 && addr_is(wr_addr, KEY_ADDR_H) && wr_data == OP_LOCK) begin
        cmd_hit = 1'b1;
        en_done = 1'b1;
        st_d    = MS_IDLE;
      end else if (step_fits(st_q, wr_addr, wr_data)) begin
        cmd_hit = 1'b1;
        if (st_q == MS_D5) begin
          dis_done = 1'b1;
          st_d     = MS_IDLE;
        end else begin
          st_d = mstate_t'(st_q + 3'd1);
        end
      end else if (step_fits(MS_IDLE, wr_addr, wr_data)) begin
        cmd_hit = 1'b1;
        st_d    = MS_A1;
      end else begin
        st_d = MS_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= MS_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/wprot_gate.sv
module wprot_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_evt,
  input  logic cmd_hit,
  input  logic en_done,
  input  logic dis_done,
  input  logic page_done,
  output logic prot_on,
  output logic win_open,
  output logic wr_allow,
  output logic cmd_suppress
);
  logic prot_q, win_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prot_q <= 1'b0;
      win_q  <= 1'b0;
    end else if (en_done) begin
      prot_q <= 1'b1;
      win_q  <= 1'b1;
    end else if (dis_done) begin
      prot_q <= 1'b0;
      win_q  <= 1'b0;
    end else if (page_done) begin
      win_q  <= 1'b0;
    end
  end

  assign prot_on      = prot_q;
  assign win_open     = win_q;
  assign cmd_suppress = wr_evt & cmd_hit;
  assign wr_allow     = wr_evt & ~cmd_hit & (~prot_q | win_q);
endmodule

// File: rtl/wprot_seq.sv
module wprot_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_evt,
  input  logic [15:0] wr_addr,
  input  logic [7:0]  wr_data,
  input  logic        page_done,
  output logic        prot_on,
  output logic        wr_allow,
  output logic        cmd_suppress
);
  logic cmd_hit, en_done, dis_done, win_open;

  wprot_cmd_match u_match (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .wr_addr(wr_addr),
    .wr_data(wr_data), .cmd_hit(cmd_hit), .en_done(en_done), .dis_done(dis_done)
  );

  wprot_gate u_gate (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .cmd_hit(cmd_hit),
    .en_done(en_done), .dis_done(dis_done), .page_done(page_done),
    .prot_on(prot_on), .win_open(win_open), .wr_allow(wr_allow),
    .cmd_suppress(cmd_suppress)
  );
endmodule

// File: rtl/wprot_chk.sv
module wprot_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_evt,
  input logic wr_allow,
  input logic cmd_suppress,
  input logic prot_on,
  input logic win_open,
  input logic en_done,
  input logic dis_done,
  input logic page_done
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_evt |-> (!wr_allow && !cmd_suppress));
  assert_lock_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en_done |=> (prot_on && win_open));
  assert_close_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (page_done && !en_done && !dis_done) |=> !win_open);
  assert_win_needs_prot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |-> prot_on);
  assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dis_done |=> (!prot_on && !win_open));
  assert_cmd_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_suppress |-> !wr_allow);
  assert_locked_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_on && !win_open) |-> !wr_allow);
endmodule

bind wprot_seq wprot_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .wr_allow(wr_allow),
  .cmd_suppress(cmd_suppress), .prot_on(prot_on), .win_open(win_open),
  .en_done(en_done), .dis_done(dis_done), .page_done(page_done)
);

// File: tb/wprot_seq_bench.sv
module wprot_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_evt = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic page_done = 1'b0;
  logic prot_on, wr_allow, cmd_suppress;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  int m_step = 0;
  bit m_prot = 0;
  bit m_win = 0;

  always #5 clk = ~clk;

  wprot_seq u_wprot_seq (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .wr_addr(wr_addr),
    .wr_data(wr_data), .page_done(page_done), .prot_on(prot_on),
    .wr_allow(wr_allow), .cmd_suppress(cmd_suppress)
  );

  // release string, index k: its step k; the lock string shares steps 0 and 1
  function automatic logic [15:0] seq_a(int k);
    return (k == 1 || k == 4) ? 16'h2AAA : 16'h5555;
  endfunction
  function automatic logic [7:0] seq_d(int k);
    case (k)
      0, 3: return 8'hAA;
      1, 4: return 8'h55;
      2: return 8'h80;
      default: return 8'h20;
    endcase
  endfunction
  function automatic bit same(logic [15:0] a, logic [7:0] d, int k);
    return a[14:0] == seq_a(k)[14:0] && d == seq_d(k);
  endfunction

  task automatic check1(string tag, string what, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit e, logic [15:0] a, logic [7:0] d, bit pd);
    bit hit, en, dis;
    @(negedge clk);
    wr_evt = e; wr_addr = a; wr_data = d; page_done = pd;
    hit = 0; en = 0; dis = 0;
    if (e) begin
      if (m_step == 2 && a[14:0] == 15'h5555 && d == 8'hA0) begin
        hit = 1; en = 1; m_step = 0;
      end else if (same(a, d, m_step)) begin
        hit = 1;
        if (m_step == 5) begin dis = 1; m_step = 0; end
        else m_step++;
      end else if (same(a, d, 0)) begin
        hit = 1; m_step = 1;
      end else m_step = 0;
    end
    #1;
    check1(tag, "prot_on", prot_on, m_prot);
    check1(tag, "cmd_suppress", cmd_suppress, e && hit);
    check1(tag, "wr_allow", wr_allow, e && !hit && (!m_prot || m_win));
    if (en) begin m_prot = 1; m_win = 1; end
    else if (dis) begin m_prot = 0; m_win = 0; end
    else if (pd) m_win = 0;
  endtask

  task automatic wr(string tag, logic [15:0] a, logic [7:0] d);
    step(tag, 1, a, d, 0);
  endtask
  task automatic lock_seq(string tag, logic [15:0] hi);
    wr(tag, 16'h5555 | hi, 8'hAA);
    wr(tag, 16'h2AAA | hi, 8'h55);
    wr(tag, 16'h5555 | hi, 8'hA0);
  endtask
  task automatic release_seq(string tag);
    for (int k = 0; k < 6; k++) wr(tag, seq_a(k), seq_d(k));
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned s0;
    s0 = $urandom(32'd1357);
    repeat (3) @(negedge clk);
    #1;
    check1("R1", "prot_on in reset", prot_on, 1'b0);
    rst_n = 1'b1;
    step("R1", 0, 16'h1234, 8'h00, 0);
    wr("R1", 16'h0100, 8'h3C);
    // lock from open mode; every byte is held back
    lock_seq("R6 R2", 16'h0000);
    wr("R3", 16'h0400, 8'h11);
    wr("R3", 16'h0401, 8'h12);
    step("R3", 0, 16'h0, 8'h0, 1);
    wr("R8", 16'h0402, 8'h13);
    wr("R8", 16'h7777, 8'h99);
    // lock again with bit 15 set, while already protected
    lock_seq("R5 R2", 16'h8000);
    // write together with page_done: still allowed, then closed
    step("R10", 1, 16'h0500, 8'h21, 1);
    wr("R10", 16'h0501, 8'h22);
    // broken string: third byte wrong, then a lone branch byte
    wr("R7", 16'h5555, 8'hAA);
    wr("R7", 16'h2AAA, 8'h55);
    wr("R7", 16'h0600, 8'h00);
    wr("R7", 16'h5555, 8'h80);
    // restart on a repeated first byte
    wr("R7", 16'h5555, 8'hAA);
    wr("R7", 16'hD555, 8'hAA);
    wr("R7", 16'h2AAA, 8'h55);
    // last lock byte together with page_done: window opens
    step("R10", 1, 16'h5555, 8'hA0, 1);
    wr("R10", 16'h0700, 8'h44);
    // release branch picked by third byte
    release_seq("R9 R4");
    wr("R4", 16'h0800, 8'h55);
    lock_seq("R2", 16'h0000);
    step("R3", 0, 16'h0, 8'h0, 1);
    release_seq("R4");
    // random phase, biased toward command bytes
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      logic [15:0] a;
      logic [7:0] d;
      bit pd;
      r = $urandom % 8;
      pd = ($urandom % 6) == 0;
      a = 16'($urandom);
      d = 8'($urandom);
      if (r < 4) begin
        int k;
        k = (m_step == 2 && ($urandom % 2 == 0)) ? -1 : m_step;
        if (k < 0) begin a = 16'h5555; d = 8'hA0; end
        else begin a = seq_a(k); d = seq_d(k); end
        if ($urandom % 2 == 0) a[15] = 1'b1;
        step("RND R6 R7", 1, a, d, pd);
      end else if (r == 7) begin
        int k;
        k = $urandom % 6;
        step("RND R7", 1, seq_a(k), seq_d(k), pd);
      end else if (r < 6) step("RND R8 R3", 1, a, d, pd);
      else step("RND R10", 0, a, d, pd);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule